// File: doc/BRIEF.md
# I2C Bus Wiring Self-Test Scanner

This block checks, one bus after another, that the clock and data lines of a small group of I2C buses are really connected between the chip's open-drain drivers and its input pins. A single start pulse begins a scan. For each selected bus the block parks the bus with a STOP sequence. It then applies two opposite line patterns and reads both lines back through input synchronizers after each one. In the first pattern the clock is pulled low and the data line is released. In the second the clock is released and the data line is pulled low.

A bus that reads back both patterns correctly is marked as passing and parked again with a second STOP. A bus that misreads either pattern is dropped at once, its lines are released and the scan moves on. A line that is swapped, shorted to its partner, left floating high or stuck low fails at least one of the two patterns. A configuration input chooses whether all buses or all but the last are scanned. When the scan ends, the block raises a done flag and holds a per-bus pass vector and an overall pass flag until the next start.

All waits are whole multiples of a time unit of `UNIT_CYC` clock cycles, nominally one microsecond. Outputs are pull-low enables: 1 drives the wire low and 0 releases it. Inputs read 1 when the wire is high.

Top module: `i2c_wiring_scan`

## Requirements
- R1: While reset is asserted, and right after it, every pull-low output is 0 and `done`, `bus_ok` and `any_ok` are all 0.
- R2: A `start` pulse while no scan is running clears `bus_ok` and `any_ok` and drops `done` on the next clock edge. A `start` during a scan has no effect. After a scan, `done`, `bus_ok` and `any_ok` hold their values until the next `start`, whatever the bus lines do.
- R3: A bus whose inputs follow its pull-low outputs (input = NOT pull) gets its `bus_ok` bit set to 1.
- R4: A bus whose clock and data inputs are swapped, or are shorted together (both read the wired-AND of the two drives), gets its `bus_ok` bit at 0.
- R5: A bus with both lines stuck high, both lines stuck low, or only the data line stuck high gets its `bus_ok` bit at 0. The data-stuck-high case fails only at the second pattern.
- R6: The `three_bus` input is sampled at `start`. With 1, buses 0 to NUM_BUS-1 are scanned. With 0, bus NUM_BUS-1 is skipped: its `bus_ok` bit is 0 and its pull-low outputs stay 0 for the whole scan.
- R7: Whenever `done` is 1, `any_ok` is 1 exactly when at least one `bus_ok` bit is 1.
- R8: Buses are handled one at a time in ascending index order. At most one bus has a pull-low output active in any cycle. All pull-low outputs are 0 while `done` is 1.
- R9: Each scanned bus first gets a STOP (data pulled low, clock released, data released). A passing bus gets a second STOP, so its data line is pulled low in exactly two separate intervals. A bus that fails the first pattern gets no second STOP and shows exactly one data pull-low interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that begins a scan when idle |
| three_bus | input | 1 | 1: scan all NUM_BUS buses; 0: skip the last bus |
| scl_in | input | NUM_BUS | Clock line level per bus (1 = high) |
| sda_in | input | NUM_BUS | Data line level per bus (1 = high) |
| scl_pull | output | NUM_BUS | Clock pull-low enable per bus (1 = drive low) |
| sda_pull | output | NUM_BUS | Data pull-low enable per bus (1 = drive low) |
| bus_ok | output | NUM_BUS | Per-bus wiring pass result |
| any_ok | output | 1 | At least one bus passed |
| done | output | 1 | Scan finished; results valid and held |

## Verification
The scan is run against a bus model that can give each bus correct wiring, swapped lines, shorted lines, both lines stuck high, both stuck low, or only the data line stuck high. Correct wiring against swapped or shorted wiring shows whether both patterns are really compared. The all-stuck cases catch a check that looks at only one line. The data-stuck-high case passes the first pattern and fails the second, so it isolates the second comparison. Counting data pull-low intervals per bus tells a passing bus (two STOPs) from one dropped after the first pattern (one STOP). The order of first activity on each bus confirms ascending scan order. Runs with the last bus deselected confirm that its lines and result bit stay untouched.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,    // settle before the first STOP
    ST_SPA,    // STOP: data pulled low
    ST_SPB,    // STOP: clock released
    ST_SPC,    // STOP: data released
    ST_GAP,    // settle after the first STOP
    ST_T1A,    // pattern 1: clock pulled low
    ST_T1B,    // pattern 1: data released, then compare
    ST_HOLD,   // settle between patterns
    ST_T2A,    // pattern 2: clock released
    ST_T2B,    // pattern 2: data pulled low, then compare
    ST_POST,   // settle before the parking STOP
    ST_NEXT    // release lines and pick the next bus
  } scan_st_t;

  // Dwell time of each state in time units.
  function automatic int unsigned st_units(scan_st_t s);
    case (s)
      ST_PRE, ST_SPC, ST_GAP: return 6;
      ST_SPB:                 return 9;
      ST_SPA, ST_T1A, ST_T1B, ST_HOLD,
      ST_T2A, ST_T2B, ST_POST: return 3;
      default:                return 1;
    endcase
  endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stg [STAGES];

  // Released bus lines idle high, so the chain resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;
    end else begin
      stg[0] <= d_in;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/i2cw_timer.sv
module i2cw_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq
  import i2cw_pkg::*;
#(
  parameter int NUM_BUS  = 3,
  parameter int UNIT_CYC = 125
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       three_bus,
  input  logic [NUM_BUS-1:0]         scl_s,
  input  logic [NUM_BUS-1:0]         sda_s,
  output logic [$clog2(NUM_BUS)-1:0] bus_idx,
  output logic                       scl_drv,
  output logic                       sda_drv,
  output logic [NUM_BUS-1:0]         bus_ok,
  output logic                       any_ok,
  output logic                       done,
  output logic                       all_bus
);
  localparam int IW = $clog2(NUM_BUS);
  localparam int TW = $clog2(9 * UNIT_CYC + 1);

  scan_st_t           st_q, st_d;
  logic [IW-1:0]      idx_q, idx_d, last_idx;
  logic               scl_q, scl_d, sda_q, sda_d;
  logic               fin_q, fin_d;
  logic [NUM_BUS-1:0] ok_q, ok_d;
  logic               any_q, any_d, done_q, done_d, all_q, all_d;
  logic               adv, expired, scl_hi, sda_hi;
  logic [TW-1:0]      load_val;

  i2cw_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (adv),
    .load_val (load_val),
    .expired  (expired)
  );

  assign load_val = TW'(st_units(st_d) * UNIT_CYC - 1);
  assign last_idx = all_q ? IW'(NUM_BUS - 1) : IW'(NUM_BUS - 2);
  assign scl_hi   = scl_s[idx_q];
  assign sda_hi   = sda_s[idx_q];

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    fin_d  = fin_q;
    ok_d   = ok_q;
    any_d  = any_q;
    done_d = done_q;
    all_d  = all_q;
    adv    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_PRE;
          idx_d  = '0;
          ok_d   = '0;
          any_d  = 1'b0;
          done_d = 1'b0;
          all_d  = three_bus;
          fin_d  = 1'b0;
          adv    = 1'b1;
        end
      end
      ST_NEXT: begin
        scl_d = 1'b0;
        sda_d = 1'b0;
        if (idx_q == last_idx) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + IW'(1);
          fin_d = 1'b0;
          st_d  = ST_PRE;
          adv   = 1'b1;
        end
      end
      default: begin
        if (expired) begin
          adv = 1'b1;
          case (st_q)
            ST_PRE:  st_d = ST_SPA;
            ST_SPA:  st_d = ST_SPB;
            ST_SPB:  st_d = ST_SPC;
            ST_SPC:  st_d = fin_q ? ST_NEXT : ST_GAP;
            ST_GAP:  st_d = ST_T1A;
            ST_T1A:  st_d = ST_T1B;
            ST_T1B:  st_d = (!scl_hi && sda_hi) ? ST_HOLD : ST_NEXT;
            ST_HOLD: st_d = ST_T2A;
            ST_T2A:  st_d = ST_T2B;
            ST_T2B: begin
              if (scl_hi && !sda_hi) begin
                ok_d[idx_q] = 1'b1;
                any_d       = 1'b1;
                st_d        = ST_POST;
              end else begin
                st_d = ST_NEXT;
              end
            end
            ST_POST: begin
              st_d  = ST_SPA;
              fin_d = 1'b1;
            end
            default: st_d = ST_NEXT;
          endcase
          // line action on entry to the new state
          case (st_d)
            ST_SPA: sda_d = 1'b1;
            ST_SPB: scl_d = 1'b0;
            ST_SPC: sda_d = 1'b0;
            ST_T1A: scl_d = 1'b1;
            ST_T1B: sda_d = 1'b0;
            ST_T2A: scl_d = 1'b0;
            ST_T2B: sda_d = 1'b1;
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      fin_q  <= 1'b0;
      ok_q   <= '0;
      any_q  <= 1'b0;
      done_q <= 1'b0;
      all_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      fin_q  <= fin_d;
      ok_q   <= ok_d;
      any_q  <= any_d;
      done_q <= done_d;
      all_q  <= all_d;
    end
  end

  assign bus_idx = idx_q;
  assign scl_drv = scl_q;
  assign sda_drv = sda_q;
  assign bus_ok  = ok_q;
  assign any_ok  = any_q;
  assign done    = done_q;
  assign all_bus = all_q;
endmodule

// File: rtl/i2c_wiring_scan.sv
module i2c_wiring_scan #(
  parameter int NUM_BUS     = 3,
  parameter int UNIT_CYC    = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               three_bus,
  input  logic [NUM_BUS-1:0] scl_in,
  input  logic [NUM_BUS-1:0] sda_in,
  output logic [NUM_BUS-1:0] scl_pull,
  output logic [NUM_BUS-1:0] sda_pull,
  output logic [NUM_BUS-1:0] bus_ok,
  output logic               any_ok,
  output logic               done
);
  localparam int IW = $clog2(NUM_BUS);

  logic [1:0]           rst_pipe;
  logic                 rst_i;
  logic [2*NUM_BUS-1:0] lines_s;
  logic [IW-1:0]        bus_idx;
  logic                 scl_drv, sda_drv, all_bus;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  i2cw_sync #(.WIDTH(2 * NUM_BUS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d_in  ({sda_in, scl_in}),
    .q_out (lines_s)
  );

  i2cw_seq #(.NUM_BUS(NUM_BUS), .UNIT_CYC(UNIT_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i),
    .start     (start),
    .three_bus (three_bus),
    .scl_s     (lines_s[NUM_BUS-1:0]),
    .sda_s     (lines_s[2*NUM_BUS-1:NUM_BUS]),
    .bus_idx   (bus_idx),
    .scl_drv   (scl_drv),
    .sda_drv   (sda_drv),
    .bus_ok    (bus_ok),
    .any_ok    (any_ok),
    .done      (done),
    .all_bus   (all_bus)
  );

  // route the shared drive pair to the bus under test only
  for (genvar g = 0; g < NUM_BUS; g++) begin : g_route
    assign scl_pull[g] = scl_drv && (bus_idx == IW'(g));
    assign sda_pull[g] = sda_drv && (bus_idx == IW'(g));
  end
endmodule

// File: rtl/i2c_wiring_scan_chk.sv
module i2c_wiring_scan_chk #(
  parameter int NUM_BUS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               done,
  input logic               any_ok,
  input logic [NUM_BUS-1:0] bus_ok,
  input logic [NUM_BUS-1:0] scl_pull,
  input logic [NUM_BUS-1:0] sda_pull,
  input logic               all_bus
);
  p_released_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_pull == '0 && sda_pull == '0));

  p_one_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(scl_pull | sda_pull));

  p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(bus_ok) && $stable(any_ok)));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && bus_ok == '0 && !any_ok));

  p_any_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (any_ok == (|bus_ok)));

  p_skip_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !all_bus |-> (!scl_pull[NUM_BUS-1] && !sda_pull[NUM_BUS-1]));

  p_skip_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !all_bus) |-> !bus_ok[NUM_BUS-1]);
endmodule

bind i2c_wiring_scan i2c_wiring_scan_chk #(.NUM_BUS(NUM_BUS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .any_ok   (any_ok),
  .bus_ok   (bus_ok),
  .scl_pull (scl_pull),
  .sda_pull (sda_pull),
  .all_bus  (all_bus)
);

// File: tb/i2c_wiring_scan_tb.sv
module i2c_wiring_scan_tb;
  localparam int NB = 3;
  localparam int UC = 8;

  // fault modes of the bus model
  localparam logic [2:0] M_OK = 3'd0, M_SWAP = 3'd1, M_SHORT = 3'd2,
                         M_HI = 3'd3, M_LO = 3'd4, M_SDAHI = 3'd5;

  // {three_bus, mode2, mode1, mode0}
  localparam logic [9:0] VEC [6] = '{
    10'b1_000_000_000,
    10'b1_010_000_001,
    10'b0_000_000_000,
    10'b1_000_100_011,
    10'b1_100_010_101,
    10'b0_001_000_001
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start, three_bus;
  logic [NB-1:0] scl_in, sda_in, scl_pull, sda_pull, bus_ok;
  logic          any_ok, done;
  logic [2:0]    mode [NB];

  int total = 0, bad = 0, cyc = 0;
  int ep [NB];
  int first_t [NB];
  logic [NB-1:0] prev_sda = '0;

  i2c_wiring_scan #(.NUM_BUS(NB), .UNIT_CYC(UC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .three_bus(three_bus),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .bus_ok(bus_ok), .any_ok(any_ok), .done(done)
  );

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      case (mode[i])
        M_SWAP:  begin scl_in[i] = ~sda_pull[i]; sda_in[i] = ~scl_pull[i]; end
        M_SHORT: begin scl_in[i] = ~(scl_pull[i] | sda_pull[i]); sda_in[i] = scl_in[i]; end
        M_HI:    begin scl_in[i] = 1'b1; sda_in[i] = 1'b1; end
        M_LO:    begin scl_in[i] = 1'b0; sda_in[i] = 1'b0; end
        M_SDAHI: begin scl_in[i] = ~scl_pull[i]; sda_in[i] = 1'b1; end
        default: begin scl_in[i] = ~scl_pull[i]; sda_in[i] = ~sda_pull[i]; end
      endcase
    end
  end

  // observe line activity away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < NB; i++) begin
      if (sda_pull[i] && !prev_sda[i]) ep[i] = ep[i] + 1;
      if ((sda_pull[i] || scl_pull[i]) && first_t[i] < 0) first_t[i] = cyc;
    end
    prev_sda = sda_pull;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_obs();
    for (int i = 0; i < NB; i++) begin ep[i] = 0; first_t[i] = -1; end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (!done) check(1'b0, "R2", "scan never finished", 0, 1);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  function automatic string req_of(input logic [2:0] m);
    if (m == M_OK) return "R3";
    if (m == M_SWAP || m == M_SHORT) return "R4";
    return "R5";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; three_bus = 1'b1;
    for (int i = 0; i < NB; i++) mode[i] = M_OK;
    clear_obs();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(scl_pull == '0 && sda_pull == '0, "R1", "pulls in reset", int'({scl_pull, sda_pull}), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(bus_ok == '0 && !any_ok, "R1", "results in reset", int'({bus_ok, any_ok}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(done == 1'b0 && scl_pull == '0 && sda_pull == '0, "R1", "after reset release",
          int'({done, scl_pull, sda_pull}), 0);

    // table of fault patterns
    for (int v = 0; v < 6; v++) begin
      logic          three;
      logic [NB-1:0] exp_ok;
      three = VEC[v][9];
      for (int i = 0; i < NB; i++) mode[i] = VEC[v][3*i +: 3];
      three_bus = three;
      clear_obs();
      pulse_start();
      three_bus = ~three;   // sampled only at start (R6)
      check(done == 1'b0, "R2", "done low after start", int'(done), 0);
      wait_done();
      exp_ok = '0;
      for (int i = 0; i < NB; i++) begin
        bit scanned;
        scanned = (i < NB - 1) || three;
        if (scanned && mode[i] == M_OK) exp_ok[i] = 1'b1;
        if (!scanned) begin
          check(bus_ok[i] == 1'b0, "R6", "skipped bus result", int'(bus_ok[i]), 0);
          check(ep[i] == 0 && first_t[i] < 0, "R6", "skipped bus lines touched", ep[i], 0);
        end else begin
          check(bus_ok[i] == exp_ok[i], req_of(mode[i]), $sformatf("vec %0d bus %0d ok", v, i),
                int'(bus_ok[i]), int'(exp_ok[i]));
          check(ep[i] == ((mode[i] == M_OK || mode[i] == M_SDAHI) ? 2 : 1), "R9",
                $sformatf("vec %0d bus %0d data pulls", v, i), ep[i],
                (mode[i] == M_OK || mode[i] == M_SDAHI) ? 2 : 1);
          if (i > 0)
            check(first_t[i] > first_t[i-1], "R8", $sformatf("vec %0d order bus %0d", v, i),
                  first_t[i], first_t[i-1] + 1);
        end
      end
      check(any_ok == (exp_ok != '0), "R7", $sformatf("vec %0d any_ok", v), int'(any_ok),
            int'(exp_ok != '0));
      check(scl_pull == '0 && sda_pull == '0, "R8", "lines released at done",
            int'({scl_pull, sda_pull}), 0);
    end

    // R2: start during a scan is ignored
    for (int i = 0; i < NB; i++) mode[i] = M_OK;
    three_bus = 1'b1;
    clear_obs();
    pulse_start();
    repeat (200) @(negedge clk);
    pulse_start();
    wait_done();
    check(bus_ok == 3'b111, "R2", "result after mid-scan start", int'(bus_ok), 7);
    check(ep[0] == 2, "R2", "bus 0 not restarted", ep[0], 2);

    // R2: results hold after done while lines change
    for (int i = 0; i < NB; i++) mode[i] = M_LO;
    repeat (300) @(negedge clk);
    check(done && bus_ok == 3'b111 && any_ok, "R2", "results held",
          int'({done, bus_ok, any_ok}), 5'b1_111_1);

    // R2: a new start clears the results
    pulse_start();
    check(!done && bus_ok == '0 && !any_ok, "R2", "results cleared by start",
          int'({done, bus_ok, any_ok}), 0);
    wait_done();
    check(bus_ok == '0 && !any_ok, "R5", "all stuck low", int'({bus_ok, any_ok}), 0);

    // R1: reset in the middle of a scan
    for (int i = 0; i < NB; i++) mode[i] = M_OK;
    pulse_start();
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(scl_pull == '0 && sda_pull == '0, "R1", "pulls on mid-scan reset",
          int'({scl_pull, sda_pull}), 0);
    check(!done && bus_ok == '0 && !any_ok, "R1", "results on mid-scan reset",
          int'({done, bus_ok, any_ok}), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule